// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter

This block turns a pair of quadrature phase signals, typically from an incremental shaft encoder, into a signed position held as two cascaded counter words. The two phase inputs are asynchronous. Each one passes through a short synchronizer chain. The block then decodes every single-phase transition into one step up or one step down, giving four steps for each full input cycle.

The low word follows the decoded steps directly. The high word moves only when the low word wraps. It moves up when the low word rolls from its maximum to zero, and down when it rolls from zero to its maximum. Together the two words form one position twice the width of a single word, and that position stays correct when the encoder changes direction. A one-cycle flag marks each wrap in the cycle the new value appears. An enable input pauses counting without losing track of the phase levels.

Top module: `quad_cascade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, both count words and both flags are cleared to zero on that edge.
- R2: With the phase levels written as (A,B), the sequence 00, 10, 11, 01, 00 (A leading B) adds one to the low word for every transition.
- R3: The reverse sequence 00, 01, 11, 10, 00 (B leading A) subtracts one from the low word for every transition.
- R4: A step up from the low word's maximum (0xFFFF) gives a low word of 0x0000. The high word goes up by one and `ovf` is high, all in the same cycle.
- R5: A step down from a low word of 0x0000 gives 0xFFFF. The high word goes down by one and `unf` is high, all in the same cycle. A reversal that crosses zero in both directions leaves the high word at its starting value.
- R6: While `en` is low, neither word changes. Phase transitions made while disabled are absorbed and do not cause a step once `en` returns high.
- R7: A sample in which both synchronized phases change together is treated as invalid and causes no step.
- R8: A phase transition shows up in the count words on the third rising clock edge after it is applied (two synchronizer stages and one count register).
- R9: `ovf` and `unf` are each one cycle wide, they are never high together, and the high word changes only in a cycle where one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| pha_in | input | 1 | Quadrature phase A, asynchronous |
| phb_in | input | 1 | Quadrature phase B, asynchronous |
| lo_count | output | 16 | Low count word |
| hi_count | output | 16 | High count word, moved by low-word wraps |
| ovf | output | 1 | One-cycle pulse on an upward low-word wrap |
| unf | output | 1 | One-cycle pulse on a downward low-word wrap |

## Verification
A phase change driven on a falling edge is first seen by the decoder after the second rising edge. The count words and the wrap flags register it on the third rising edge, so the bench samples all of them on the falling edge that follows. The bench samples the flags again one edge later, at which point they must be low again. The long run up to the low word's maximum drives one transition per clock without waiting for each result. That run is checked once it ends, after a settling wait longer than the three-edge latency.

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             pha_in,
  input  logic             phb_in,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count,
  output logic             ovf,
  output logic             unf
);

  localparam logic [CNT_W-1:0] LO_MAX  = '1;
  localparam logic [CNT_W-1:0] LO_ZERO = '0;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [SYNC_STAGES-1:0] a_sync, b_sync;
  logic a_prev, b_prev;
  logic a_now, b_now, a_chg, b_chg, single, differ;
  logic step_up, step_dn, wrap_up, wrap_dn;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_sync <= '0;
      b_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[SYNC_STAGES-2:0], pha_in};
      b_sync <= {b_sync[SYNC_STAGES-2:0], phb_in};
      a_prev <= a_now;
      b_prev <= b_now;
    end
  end

  assign a_now   = a_sync[SYNC_STAGES-1];
  assign b_now   = b_sync[SYNC_STAGES-1];
  assign a_chg   = a_now ^ a_prev;
  assign b_chg   = b_now ^ b_prev;
  assign single  = a_chg ^ b_chg;
  assign differ  = a_now ^ b_now;
  assign step_up = en & single & (a_chg ? differ : ~differ);
  assign step_dn = en & single & (a_chg ? ~differ : differ);
  assign wrap_up = step_up & (lo_count == LO_MAX);
  assign wrap_dn = step_dn & (lo_count == LO_ZERO);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_count <= '0;
      hi_count <= '0;
      ovf      <= 1'b0;
      unf      <= 1'b0;
    end else begin
      ovf <= wrap_up;
      unf <= wrap_dn;
      if (step_up)      lo_count <= lo_count + ONE;
      else if (step_dn) lo_count <= lo_count - ONE;
      if (wrap_up)      hi_count <= hi_count + ONE;
      else if (wrap_dn) hi_count <= hi_count - ONE;
    end
  end

  assert_ovf_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (lo_count == LO_ZERO) && (hi_count == $past(hi_count) + ONE));

  assert_unf_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    unf |-> (lo_count == LO_MAX) && (hi_count == $past(hi_count) - ONE));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));

  assert_hi_moves_on_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (!ovf && !unf) |-> $stable(hi_count));

  assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(lo_count) && $stable(hi_count));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(lo_count) |->
      (lo_count == $past(lo_count) + ONE) || (lo_count == $past(lo_count) - ONE));

endmodule

// File: tb/quad_cascade_counter_tb.sv
module quad_cascade_counter_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b1;
  logic pha = 1'b0, phb = 1'b0;
  logic [15:0] lo, hi;
  logic ovf, unf;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  quad_cascade_counter u_dut (.clk(clk), .rst(rst), .en(en), .pha_in(pha), .phb_in(phb),
    .lo_count(lo), .hi_count(hi), .ovf(ovf), .unf(unf));

  // {A, B, lo, hi, ovf, unf}
  localparam int NV = 10;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {1'b1, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0002, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'h0003, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b1, 16'h0002, 16'h0000, 1'b0, 1'b0},
    {1'b1, 1'b0, 16'h0001, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {1'b0, 1'b1, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1},
    {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive on a falling edge, sample after the third rising edge (R8), then confirm flags fall
  task automatic step(logic a, logic b, logic [15:0] elo, logic [15:0] ehi,
                      logic eo, logic eu, string req);
    @(negedge clk);
    pha = a; phb = b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req, " lo"}, {16'h0, lo}, {16'h0, elo});
    chk({req, " hi"}, {16'h0, hi}, {16'h0, ehi});
    chk({req, " flags"}, {30'h0, ovf, unf}, {30'h0, eo, eu});
    @(negedge clk);
    chk("R9 flag width", {30'h0, ovf, unf}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lo", {16'h0, lo}, 32'h0);
    chk("R1 reset hi", {16'h0, hi}, 32'h0);
    chk("R1 reset flags", {30'h0, ovf, unf}, 32'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      step(VEC[i][35], VEC[i][34], VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0],
           "R2/R3/R4/R5 vector");

    // R8 latency: nothing visible after two edges, visible after three
    @(negedge clk);
    pha = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet", {16'h0, lo}, 32'h0);
    @(negedge clk);
    chk("R8 due", {16'h0, lo}, 32'h1);
    @(negedge clk);
    pha = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 back", {16'h0, lo}, 32'h0);

    // R2 long upward run of 65535 steps, one per clock, from phase state 00
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      case (i % 4)
        0: begin pha = 1'b1; phb = 1'b0; end
        1: begin pha = 1'b1; phb = 1'b1; end
        2: begin pha = 1'b0; phb = 1'b1; end
        default: begin pha = 1'b0; phb = 1'b0; end
      endcase
    end
    repeat (5) @(negedge clk);
    chk("R2 run lo", {16'h0, lo}, 32'hFFFF);
    chk("R2 run hi", {16'h0, hi}, 32'h0);

    step(1'b0, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b0, "R4 carry into hi");
    step(1'b0, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 1'b1, "R5 return");

    // R6 disabled: transition absorbed
    @(negedge clk);
    en = 1'b0;
    step(1'b0, 1'b0, 16'hFFFF, 16'h0000, 1'b0, 1'b0, "R6 disabled");
    @(negedge clk);
    en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6 re-enable no step", {16'h0, lo}, 32'hFFFF);
    step(1'b1, 1'b0, 16'h0000, 16'h0001, 1'b1, 1'b0, "R6 counts after enable");

    // R7 both phases change together
    step(1'b0, 1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0, "R7 double change");
    step(1'b0, 1'b0, 16'h0001, 16'h0001, 1'b0, 1'b0, "R7 recovers");

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset lo again", {16'h0, lo}, 32'h0);
    chk("R1 reset hi again", {16'h0, hi}, 32'h0);
    rst = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule